// File: doc/BRIEF.md
# Chained DMA Channel Sequencer

This block is the engine of a single DMA channel. It moves 128-bit quadwords from memory to a peripheral port with a ready/valid handshake. Memory reads go out through a request/grant port with a separate response strobe, and only one read is ever outstanding. A register bank outside the block supplies the start pulse and the initial data address, quadword count, tag address and mode bits. It reads back the live address and count registers, the latched tag control bits, the busy level, a one-cycle done pulse and an error flag.

In plain mode the engine streams the programmed number of quadwords and then stops. In chain mode it walks a linked list of 128-bit tags stored in memory. Each tag supplies a count, an address and a kind code. The kind decides where the next block of data lives and where the next tag is read. A tag can end the list, or it can end it early through its interrupt bit. On request, the low half of each tag can be forwarded to the peripheral ahead of that tag's data.

The controller is a single state machine. Its states are IDLE, DECIDE, DREQ, DWAIT, DPUSH, TREQ, TWAIT, TCHECK, TFWD and FINISH. The transitions are:

- IDLE goes to DECIDE on start.
- DECIDE goes to DREQ while the count is non-zero. With a zero count it goes to FINISH in plain mode or when an end is pending, and to TREQ otherwise.
- DREQ goes to DWAIT on grant, and DWAIT goes to DPUSH on response. DPUSH returns to DECIDE on acceptance.
- TREQ goes to TWAIT on grant, and TWAIT goes to TCHECK on response.
- TCHECK goes to FINISH on a bad code, to TFWD when forwarding is on, and to DECIDE otherwise.
- TFWD goes to DECIDE on acceptance.
- FINISH goes to IDLE.

Top module: `qdma_chain_seq`

## Requirements
- R1: After reset and whenever idle, busy_o, done_o, err_o, mem_req_o and pv_valid_o are all low.
- R2: Each quadword accepted by the peripheral (pv_valid_o and pv_ready_i high together) adds 16 to madr_o and subtracts 1 from qwc_o. A quadword that is offered but not accepted keeps pv_data_o unchanged, and the registers do not move.
- R3: start_i in IDLE loads madr_i, qwc_i and tadr_i. In plain mode (chain_i low) the engine streams exactly qwc_i quadwords read from consecutive addresses and then ends. A zero count ends it with no data.
- R4: In chain mode a zero count with no pending end reads a tag at tadr_o. The tag loads qwc_o from bits [15:0] and tag_ctl_o from bits [31:16]. The kind code is in bits [30:28], the interrupt bit is bit 31 and the address field is in bits [62:32].
- R5: Kind 0 sets the data address to the tag's address field, sets the tag address to the old tag address plus 16, and ends once that data is sent.
- R6: Kind 1 takes data from the tag address plus 16. The next tag address becomes that data address plus 16 times the count.
- R7: Kind 2 takes data from the tag address plus 16. The next tag address becomes the tag's address field.
- R8: Kind 3 sets the data address to the address field and moves the tag address on by 16 without ending. Kind 7 takes data from the tag address plus 16 and then ends.
- R9: When irq_en_i was high at start and the tag's bit 31 is set, the channel ends after that tag's data block.
- R10: When tag_fwd_i was high at start, each valid tag's bits [63:0] are offered, zero-extended, on pv_data_o before its data. No channel register changes until the peripheral accepts them.
- R11: Ending raises done_o for exactly one cycle while busy_o is still high. busy_o is low in the next cycle, and a new start begins with no pending end.
- R12: Kind codes 4, 5 and 6 end the channel with done_o and set err_o. The address and count registers keep the values they had before that tag, and nothing is forwarded. The next start clears err_o.
- R13: While hold_i is high, mem_req_o and pv_valid_o are low. Progress resumes when hold_i drops.
- R14: A memory request keeps its address until granted, and a new request is not issued before the previous response has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| hold_i | input | 1 | global hold: suppresses memory and peripheral handshakes |
| start_i | input | 1 | start pulse, taken in IDLE only |
| chain_i | input | 1 | 1 selects chain mode |
| irq_en_i | input | 1 | allows a tag's interrupt bit to end the list |
| tag_fwd_i | input | 1 | forwards each tag's low 64 bits to the peripheral |
| madr_i | input | AW | initial data address |
| qwc_i | input | 16 | initial quadword count |
| tadr_i | input | AW | initial tag address |
| busy_o | output | 1 | channel running (start bit) |
| done_o | output | 1 | one-cycle end pulse |
| err_o | output | 1 | bad tag kind seen |
| tag_ctl_o | output | 16 | bits [31:16] of the last applied tag |
| madr_o | output | AW | live data address |
| qwc_o | output | 16 | live quadword count |
| tadr_o | output | AW | live tag address |
| mem_req_o | output | 1 | memory read request |
| mem_addr_o | output | AW | memory read address |
| mem_gnt_i | input | 1 | request accepted |
| mem_rvalid_i | input | 1 | read data valid |
| mem_rdata_i | input | 128 | read data |
| pv_valid_o | output | 1 | peripheral data valid |
| pv_data_o | output | 128 | peripheral data |
| pv_ready_i | input | 1 | peripheral accepts data |

## Verification
Several rules are checked by the bound checker on every clock:

- the address and count step on each accepted data beat, with peripheral data held stable while it waits;
- the single-cycle done pulse, followed by busy dropping;
- the error flag rising only together with done;
- silence under hold and while idle;
- a request address held until grant.

The tag walk itself can only be shown by the bench's scenarios. This covers the data address chosen by each kind code, the next tag address, ending on kinds 0 and 7 or on the interrupt bit, tag forwarding order, and the values left after a bad kind. The bench compares the full peripheral stream and the final registers against its own walk of the same memory image.

// File: rtl/qdma_pkg.sv
package qdma_pkg;

    localparam int QW_BITS      = 128;
    localparam int CNT_BITS     = 16;
    localparam int QW_SHIFT     = 4;
    localparam int QW_BYTES     = 1 << QW_SHIFT;
    localparam int CTL_BITS     = 16;
    localparam int CTL_LSB      = 16;
    localparam int KIND_LSB     = 28;
    localparam int KIND_BITS    = 3;
    localparam int IRQ_BIT      = 31;
    localparam int FLD_ADR_LSB  = 32;
    localparam int FLD_ADR_BITS = 31;
    localparam int TAG_USED     = FLD_ADR_LSB + FLD_ADR_BITS;
    localparam int FWD_BITS     = 64;

    typedef enum logic [KIND_BITS-1:0] {
        K_REF_END = 3'd0,
        K_COUNT   = 3'd1,
        K_JUMP    = 3'd2,
        K_REF     = 3'd3,
        K_BAD4    = 3'd4,
        K_BAD5    = 3'd5,
        K_BAD6    = 3'd6,
        K_END     = 3'd7
    } tag_kind_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DECIDE,
        S_DREQ,
        S_DWAIT,
        S_DPUSH,
        S_TREQ,
        S_TWAIT,
        S_TCHECK,
        S_TFWD,
        S_FINISH
    } seq_state_e;

endpackage

// File: rtl/qdma_tag_decode.sv
module qdma_tag_decode
    import qdma_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [TAG_USED-1:0] tag_i,
    input  logic [AW-1:0]       tadr_i,
    input  logic                irq_en_i,
    output logic                kind_ok_o,
    output logic [AW-1:0]       madr_o,
    output logic [AW-1:0]       tadr_o,
    output logic [CNT_BITS-1:0] qwc_o,
    output logic [CTL_BITS-1:0] ctl_o,
    output logic                end_o
);

    localparam logic [AW-1:0] STEP = AW'(QW_BYTES);

    logic [AW-1:0]        field_adr;
    logic [AW-1:0]        after_tag;
    logic [AW-1:0]        span;
    logic [KIND_BITS-1:0] kind;

    generate
        if (AW > FLD_ADR_BITS) begin : g_adr_ext
            assign field_adr = {{(AW-FLD_ADR_BITS){1'b0}}, tag_i[FLD_ADR_LSB +: FLD_ADR_BITS]};
        end else begin : g_adr_cut
            assign field_adr = tag_i[FLD_ADR_LSB +: AW];
        end
    endgenerate

    assign qwc_o     = tag_i[CNT_BITS-1:0];
    assign ctl_o     = tag_i[CTL_LSB +: CTL_BITS];
    assign kind      = tag_i[KIND_LSB +: KIND_BITS];
    assign after_tag = tadr_i + STEP;
    assign span      = AW'(qwc_o) << QW_SHIFT;

    always_comb begin
        kind_ok_o = 1'b1;
        madr_o    = after_tag;
        tadr_o    = tadr_i;
        end_o     = 1'b0;
        unique case (kind)
            K_REF_END: begin
                madr_o = field_adr;
                tadr_o = after_tag;
                end_o  = 1'b1;
            end
            K_COUNT: begin
                tadr_o = after_tag + span;
            end
            K_JUMP: begin
                tadr_o = field_adr;
            end
            K_REF: begin
                madr_o = field_adr;
                tadr_o = after_tag;
            end
            K_END: begin
                end_o  = 1'b1;
            end
            default: begin
                kind_ok_o = 1'b0;
            end
        endcase
        if (irq_en_i && tag_i[IRQ_BIT]) begin
            end_o = 1'b1;
        end
    end

endmodule

// File: rtl/qdma_chan_regs.sv
module qdma_chan_regs
    import qdma_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ld_cfg_i,
    input  logic                cfg_chain_i,
    input  logic                cfg_irq_en_i,
    input  logic                cfg_fwd_i,
    input  logic [AW-1:0]       cfg_madr_i,
    input  logic [CNT_BITS-1:0] cfg_qwc_i,
    input  logic [AW-1:0]       cfg_tadr_i,
    input  logic                ld_tag_i,
    input  logic [AW-1:0]       tag_madr_i,
    input  logic [AW-1:0]       tag_tadr_i,
    input  logic [CNT_BITS-1:0] tag_qwc_i,
    input  logic [CTL_BITS-1:0] tag_ctl_i,
    input  logic                tag_end_i,
    input  logic                step_i,
    input  logic                cap_i,
    input  logic [QW_BITS-1:0]  cap_data_i,
    input  logic                clr_end_i,
    input  logic                set_err_i,
    output logic                chain_o,
    output logic                irq_en_o,
    output logic                fwd_o,
    output logic [AW-1:0]       madr_o,
    output logic [CNT_BITS-1:0] qwc_o,
    output logic [AW-1:0]       tadr_o,
    output logic [CTL_BITS-1:0] ctl_o,
    output logic                end_pend_o,
    output logic [QW_BITS-1:0]  buf_o,
    output logic                err_o
);

    localparam logic [AW-1:0]       STEP = AW'(QW_BYTES);
    localparam logic [CNT_BITS-1:0] ONE  = CNT_BITS'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_o    <= 1'b0;
            irq_en_o   <= 1'b0;
            fwd_o      <= 1'b0;
            madr_o     <= '0;
            qwc_o      <= '0;
            tadr_o     <= '0;
            ctl_o      <= '0;
            end_pend_o <= 1'b0;
            err_o      <= 1'b0;
        end else if (ld_cfg_i) begin
            chain_o    <= cfg_chain_i;
            irq_en_o   <= cfg_irq_en_i;
            fwd_o      <= cfg_fwd_i;
            madr_o     <= cfg_madr_i;
            qwc_o      <= cfg_qwc_i;
            tadr_o     <= cfg_tadr_i;
            ctl_o      <= '0;
            end_pend_o <= 1'b0;
            err_o      <= 1'b0;
        end else begin
            if (ld_tag_i) begin
                madr_o     <= tag_madr_i;
                tadr_o     <= tag_tadr_i;
                qwc_o      <= tag_qwc_i;
                ctl_o      <= tag_ctl_i;
                end_pend_o <= tag_end_i;
            end else if (step_i) begin
                madr_o <= madr_o + STEP;
                qwc_o  <= qwc_o - ONE;
            end
            if (clr_end_i) begin
                end_pend_o <= 1'b0;
            end
            if (set_err_i) begin
                err_o <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_o <= '0;
        end else if (cap_i) begin
            buf_o <= cap_data_i;
        end
    end

endmodule

// File: rtl/qdma_chain_seq.sv
module qdma_chain_seq
    import qdma_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hold_i,
    input  logic                start_i,
    input  logic                chain_i,
    input  logic                irq_en_i,
    input  logic                tag_fwd_i,
    input  logic [AW-1:0]       madr_i,
    input  logic [CNT_BITS-1:0] qwc_i,
    input  logic [AW-1:0]       tadr_i,
    output logic                busy_o,
    output logic                done_o,
    output logic                err_o,
    output logic [CTL_BITS-1:0] tag_ctl_o,
    output logic [AW-1:0]       madr_o,
    output logic [CNT_BITS-1:0] qwc_o,
    output logic [AW-1:0]       tadr_o,
    output logic                mem_req_o,
    output logic [AW-1:0]       mem_addr_o,
    input  logic                mem_gnt_i,
    input  logic                mem_rvalid_i,
    input  logic [QW_BITS-1:0]  mem_rdata_i,
    output logic                pv_valid_o,
    output logic [QW_BITS-1:0]  pv_data_o,
    input  logic                pv_ready_i
);

    seq_state_e state_q;
    seq_state_e state_d;

    logic                chain_q, irq_en_q, fwd_q, end_pend_q;
    logic [QW_BITS-1:0]  buf_q;

    logic                ld_cfg, ld_tag, step, cap, clr_end, set_err;
    logic                beat_is_tag;

    logic                dec_ok, dec_end;
    logic [AW-1:0]       dec_madr, dec_tadr;
    logic [CNT_BITS-1:0] dec_qwc;
    logic [CTL_BITS-1:0] dec_ctl;

    qdma_tag_decode #(.AW(AW)) u_decode (
        .tag_i     (buf_q[TAG_USED-1:0]),
        .tadr_i    (tadr_o),
        .irq_en_i  (irq_en_q),
        .kind_ok_o (dec_ok),
        .madr_o    (dec_madr),
        .tadr_o    (dec_tadr),
        .qwc_o     (dec_qwc),
        .ctl_o     (dec_ctl),
        .end_o     (dec_end)
    );

    qdma_chan_regs #(.AW(AW)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .ld_cfg_i     (ld_cfg),
        .cfg_chain_i  (chain_i),
        .cfg_irq_en_i (irq_en_i),
        .cfg_fwd_i    (tag_fwd_i),
        .cfg_madr_i   (madr_i),
        .cfg_qwc_i    (qwc_i),
        .cfg_tadr_i   (tadr_i),
        .ld_tag_i     (ld_tag),
        .tag_madr_i   (dec_madr),
        .tag_tadr_i   (dec_tadr),
        .tag_qwc_i    (dec_qwc),
        .tag_ctl_i    (dec_ctl),
        .tag_end_i    (dec_end),
        .step_i       (step),
        .cap_i        (cap),
        .cap_data_i   (mem_rdata_i),
        .clr_end_i    (clr_end),
        .set_err_i    (set_err),
        .chain_o      (chain_q),
        .irq_en_o     (irq_en_q),
        .fwd_o        (fwd_q),
        .madr_o       (madr_o),
        .qwc_o        (qwc_o),
        .tadr_o       (tadr_o),
        .ctl_o        (tag_ctl_o),
        .end_pend_o   (end_pend_q),
        .buf_o        (buf_q),
        .err_o        (err_o)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start_i) state_d = S_DECIDE;
            S_DECIDE: begin
                if (qwc_o != '0)                 state_d = S_DREQ;
                else if (!chain_q || end_pend_q) state_d = S_FINISH;
                else                             state_d = S_TREQ;
            end
            S_DREQ:   if (!hold_i && mem_gnt_i) state_d = S_DWAIT;
            S_DWAIT:  if (mem_rvalid_i)         state_d = S_DPUSH;
            S_DPUSH:  if (!hold_i && pv_ready_i) state_d = S_DECIDE;
            S_TREQ:   if (!hold_i && mem_gnt_i) state_d = S_TWAIT;
            S_TWAIT:  if (mem_rvalid_i)         state_d = S_TCHECK;
            S_TCHECK: begin
                if (!dec_ok)    state_d = S_FINISH;
                else if (fwd_q) state_d = S_TFWD;
                else            state_d = S_DECIDE;
            end
            S_TFWD:   if (!hold_i && pv_ready_i) state_d = S_DECIDE;
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // outputs and register controls
    always_comb begin
        ld_cfg      = (state_q == S_IDLE) && start_i;
        cap         = ((state_q == S_DWAIT) || (state_q == S_TWAIT)) && mem_rvalid_i;
        step        = (state_q == S_DPUSH) && !hold_i && pv_ready_i;
        ld_tag      = ((state_q == S_TCHECK) && dec_ok && !fwd_q)
                   || ((state_q == S_TFWD) && !hold_i && pv_ready_i);
        set_err     = (state_q == S_TCHECK) && !dec_ok;
        clr_end     = (state_q == S_FINISH);
        done_o      = (state_q == S_FINISH);
        busy_o      = (state_q != S_IDLE);
        mem_req_o   = ((state_q == S_DREQ) || (state_q == S_TREQ)) && !hold_i;
        mem_addr_o  = (state_q == S_TREQ) ? tadr_o : madr_o;
        beat_is_tag = (state_q == S_TFWD);
        pv_valid_o  = ((state_q == S_DPUSH) || beat_is_tag) && !hold_i;
        pv_data_o   = beat_is_tag ? {{(QW_BITS-FWD_BITS){1'b0}}, buf_q[FWD_BITS-1:0]} : buf_q;
    end

endmodule

// File: rtl/qdma_chain_chk.sv
module qdma_chain_chk
    import qdma_pkg::*;
#(
    parameter int AW = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                hold_i,
    input logic                busy_o,
    input logic                done_o,
    input logic                err_o,
    input logic                mem_req_o,
    input logic                mem_gnt_i,
    input logic [AW-1:0]       mem_addr_o,
    input logic                pv_valid_o,
    input logic                pv_ready_i,
    input logic [QW_BITS-1:0]  pv_data_o,
    input logic [AW-1:0]       madr_o,
    input logic [CNT_BITS-1:0] qwc_o,
    input logic                beat_is_tag
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!mem_req_o && !pv_valid_o && !done_o)); // R1

    AST_DATA_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pv_valid_o && pv_ready_i && !beat_is_tag) |=>
        (madr_o == $past(madr_o) + AW'(QW_BYTES) && qwc_o == $past(qwc_o) - CNT_BITS'(1))); // R2

    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (pv_valid_o && !pv_ready_i) |=> $stable(pv_data_o)); // R2

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o)); // R11

    AST_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(done_o)); // R11

    AST_ERR_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> done_o); // R12

    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |-> (!mem_req_o && !pv_valid_o)); // R13

    AST_REQ_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_gnt_i) |=> $stable(mem_addr_o)); // R14

endmodule

bind qdma_chain_seq qdma_chain_chk #(.AW(AW)) u_chain_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hold_i      (hold_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .mem_req_o   (mem_req_o),
    .mem_gnt_i   (mem_gnt_i),
    .mem_addr_o  (mem_addr_o),
    .pv_valid_o  (pv_valid_o),
    .pv_ready_i  (pv_ready_i),
    .pv_data_o   (pv_data_o),
    .madr_o      (madr_o),
    .qwc_o       (qwc_o),
    .beat_is_tag (beat_is_tag)
);

// File: tb/test_qdma_chain_seq.sv
`timescale 1ns/1ps
module test_qdma_chain_seq;

    localparam int AW = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         hold_i = 1'b0;
    logic         start_i = 1'b0;
    logic         chain_i = 1'b0;
    logic         irq_en_i = 1'b0;
    logic         tag_fwd_i = 1'b0;
    logic [31:0]  madr_i = '0;
    logic [15:0]  qwc_i = '0;
    logic [31:0]  tadr_i = '0;
    logic         busy_o, done_o, err_o;
    logic [15:0]  tag_ctl_o;
    logic [31:0]  madr_o, tadr_o, mem_addr_o;
    logic [15:0]  qwc_o;
    logic         mem_req_o;
    logic         mem_gnt_i = 1'b0;
    logic         mem_rvalid_i = 1'b0;
    logic [127:0] mem_rdata_i = '0;
    logic         pv_valid_o;
    logic [127:0] pv_data_o;
    logic         pv_ready_i = 1'b0;

    qdma_chain_seq #(.AW(AW)) i_qdma_chain_seq (
        .clk(clk), .rst_n(rst_n), .hold_i(hold_i), .start_i(start_i),
        .chain_i(chain_i), .irq_en_i(irq_en_i), .tag_fwd_i(tag_fwd_i),
        .madr_i(madr_i), .qwc_i(qwc_i), .tadr_i(tadr_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .tag_ctl_o(tag_ctl_o),
        .madr_o(madr_o), .qwc_o(qwc_o), .tadr_o(tadr_o),
        .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_gnt_i(mem_gnt_i),
        .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
        .pv_valid_o(pv_valid_o), .pv_data_o(pv_data_o), .pv_ready_i(pv_ready_i)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;

    logic [127:0] mem [0:63];
    logic [127:0] got [0:255];
    logic [127:0] exp_s [0:255];
    int got_n = 0, exp_n = 0, done_cnt = 0, hold_viol = 0;
    bit hold_en = 1'b0;
    bit pend = 1'b0;
    logic [5:0] pend_idx = '0;

    logic [31:0] exp_madr, exp_tadr;
    logic [15:0] exp_qwc, exp_ctl;
    bit exp_err;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [127:0] act, input logic [127:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, expv);
        end
    endtask

    function automatic logic [127:0] fill(input int i);
        return {32'hC0DE_0000 | 32'(i), 32'h5A5A_0000 + 32'(i * 3), ~32'(i), 32'(i * 7 + 1)};
    endfunction

    function automatic logic [127:0] mk_tag(input int kind, input bit irq, input int q, input int adr);
        logic [30:0] a = 31'(adr);
        return {64'hFEED_F00D_1234_5678, 1'b0, a, irq, 3'(kind), 12'hABC, 16'(q)};
    endfunction

    task automatic fill_mem();
        for (int i = 0; i < 64; i++) mem[i] = fill(i);
    endtask

    // environment: memory, peripheral, hold, monitors
    always @(negedge clk) begin
        if (rst_n) begin
            mem_rvalid_i = 1'b0;
            if (pend) begin
                mem_rvalid_i = 1'b1;
                mem_rdata_i  = mem[pend_idx];
                pend = 1'b0;
            end
            hold_i     = hold_en && (($urandom % 4) == 0);
            mem_gnt_i  = ($urandom % 4) != 0;
            pv_ready_i = ($urandom % 3) != 0;
            #1;
            if (mem_req_o && mem_gnt_i) begin
                pend = 1'b1;
                pend_idx = mem_addr_o[9:4];
            end
            if (pv_valid_o && pv_ready_i && got_n < 256) begin
                got[got_n] = pv_data_o;
                got_n++;
            end
            if (hold_i && (mem_req_o || pv_valid_o)) hold_viol++;
            if (done_o) done_cnt++;
        end
    end

    // reference walk of the rules on the bench memory image
    task automatic model(input bit ch, input bit irq, input bit fwd,
                         input logic [31:0] ma, input logic [15:0] qc, input logic [31:0] ta);
        logic [31:0] m = ma, t = ta;
        int q = int'(qc);
        bit endp = 1'b0;
        logic [127:0] tg;
        logic [31:0] fa;
        exp_n = 0; exp_err = 1'b0; exp_ctl = '0;
        for (int guard = 0; guard < 100; guard++) begin
            while (q != 0) begin
                if (exp_n < 256) exp_s[exp_n] = mem[m[9:4]];
                exp_n++;
                m = m + 32'd16;
                q--;
            end
            if (!ch || endp) break;
            tg = mem[t[9:4]];
            if (tg[30:28] inside {3'd4, 3'd5, 3'd6}) begin exp_err = 1'b1; break; end
            if (fwd) begin
                if (exp_n < 256) exp_s[exp_n] = {64'h0, tg[63:0]};
                exp_n++;
            end
            q = int'(tg[15:0]);
            exp_ctl = tg[31:16];
            fa = {1'b0, tg[62:32]};
            case (tg[30:28])
                3'd0: begin m = fa; t = t + 32'd16; endp = 1'b1; end
                3'd1: begin m = t + 32'd16; t = m + 32'(q * 16); end
                3'd2: begin m = t + 32'd16; t = fa; end
                3'd3: begin m = fa; t = t + 32'd16; end
                default: begin m = t + 32'd16; endp = 1'b1; end
            endcase
            if (irq && tg[31]) endp = 1'b1;
        end
        exp_madr = m; exp_tadr = t; exp_qwc = 16'(q);
    endtask

    task automatic run(input bit ch, input bit irq, input bit fwd,
                       input logic [31:0] ma, input logic [15:0] qc, input logic [31:0] ta,
                       input string rq);
        bit hung = 1'b0;
        bit same = 1'b1;
        model(ch, irq, fwd, ma, qc, ta);
        @(negedge clk);
        got_n = 0; done_cnt = 0; hold_viol = 0;
        chain_i = ch; irq_en_i = irq; tag_fwd_i = fwd;
        madr_i = ma; qwc_i = qc; tadr_i = ta; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int c = 0; c < 5000; c++) begin
            if (!busy_o) break;
            @(negedge clk);
            if (c == 4999) hung = 1'b1;
        end
        #2;
        chk(!hung, rq, "run finished", 128'(busy_o), 128'(0));
        chk(got_n == exp_n, rq, "stream length", 128'(got_n), 128'(exp_n));
        for (int i = 0; i < got_n && i < exp_n && i < 256; i++)
            if (got[i] !== exp_s[i] && same) begin
                same = 1'b0;
                chk(1'b0, rq, $sformatf("stream beat %0d", i), got[i], exp_s[i]);
            end
        if (same) chk(1'b1, rq, "stream", '0, '0);
        chk(madr_o === exp_madr, rq, "data address", 128'(madr_o), 128'(exp_madr));
        chk(qwc_o === exp_qwc, rq, "count", 128'(qwc_o), 128'(exp_qwc));
        chk(tadr_o === exp_tadr, rq, "tag address", 128'(tadr_o), 128'(exp_tadr));
        chk(err_o === exp_err, rq, "error flag", 128'(err_o), 128'(exp_err));
        chk(tag_ctl_o === exp_ctl, rq, "tag control", 128'(tag_ctl_o), 128'(exp_ctl));
        chk(done_cnt == 1, "R11", "done pulses", 128'(done_cnt), 128'(1));
        chk(hold_viol == 0, "R13", "handshake under hold", 128'(hold_viol), 128'(0));
    endtask

    task automatic build_random(output logic [31:0] start);
        int t = 16;
        int ntags = 1 + int'($urandom % 5);
        fill_mem();
        start = 32'(t * 16);
        for (int k = 0; k < ntags; k++) begin
            int q = int'($urandom % 4);
            int kind = int'($urandom % 3);
            bit irq = ($urandom % 6) == 0;
            if (k == ntags - 1) begin
                if ($urandom % 2) mem[t] = mk_tag(0, irq, q, int'($urandom % 12) * 16);
                else              mem[t] = mk_tag(7, irq, q, 0);
            end else begin
                case (kind)
                    0: begin mem[t] = mk_tag(1, irq, q, 0); t = t + q + 1; end
                    1: begin
                        int j = t + q + 1 + int'($urandom % 3);
                        mem[t] = mk_tag(2, irq, q, j * 16);
                        t = j;
                    end
                    default: begin mem[t] = mk_tag(3, irq, q, int'($urandom % 12) * 16); t = t + 1; end
                endcase
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] st;
        void'($urandom(32'd20240611));
        fill_mem();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!busy_o && !done_o && !err_o, "R1", "status after reset",
            128'({busy_o, done_o, err_o}), 128'(0));
        chk(!mem_req_o && !pv_valid_o, "R1", "handshakes after reset",
            128'({mem_req_o, pv_valid_o}), 128'(0));

        // R3 / R2: plain mode, several beats and zero count
        run(0, 0, 0, 32'h40, 16'd5, 32'h0, "R3");
        run(0, 0, 0, 32'h80, 16'd0, 32'h0, "R3");
        run(0, 0, 1, 32'h100, 16'd3, 32'h200, "R2");

        // R5: reference-and-end
        fill_mem(); mem[20] = mk_tag(0, 0, 2, 32'h30);
        run(1, 0, 0, 32'h0, 16'd0, 32'(20 * 16), "R5");
        // R6 / R8: count then end, plus a zero-count count tag (R4)
        fill_mem(); mem[20] = mk_tag(1, 0, 2, 0); mem[23] = mk_tag(7, 0, 1, 0);
        run(1, 0, 0, 32'h0, 16'd0, 32'(20 * 16), "R6");
        fill_mem(); mem[20] = mk_tag(1, 0, 0, 0); mem[21] = mk_tag(7, 0, 2, 0);
        run(1, 0, 0, 32'h0, 16'd0, 32'(20 * 16), "R4");
        // R7: jump
        fill_mem(); mem[20] = mk_tag(2, 0, 1, 32'h300); mem[48] = mk_tag(0, 0, 1, 32'h10);
        run(1, 0, 0, 32'h0, 16'd0, 32'(20 * 16), "R7");
        // R8: reference without end
        fill_mem(); mem[20] = mk_tag(3, 0, 2, 32'h80); mem[21] = mk_tag(7, 0, 0, 0);
        run(1, 0, 0, 32'h0, 16'd0, 32'(20 * 16), "R8");
        // R9: interrupt bit ends early only when enabled
        fill_mem(); mem[20] = mk_tag(1, 1, 2, 0); mem[23] = mk_tag(7, 0, 1, 0);
        run(1, 1, 0, 32'h0, 16'd0, 32'(20 * 16), "R9");
        run(1, 0, 0, 32'h0, 16'd0, 32'(20 * 16), "R9");
        // R10: tag forwarding
        fill_mem(); mem[20] = mk_tag(1, 0, 2, 0); mem[23] = mk_tag(7, 0, 1, 0);
        run(1, 0, 1, 32'h0, 16'd0, 32'(20 * 16), "R10");
        // R12: bad kind, then cleared by the next start
        fill_mem(); mem[20] = mk_tag(1, 0, 1, 0); mem[22] = mk_tag(5, 0, 3, 32'h40);
        run(1, 0, 1, 32'h0, 16'd0, 32'(20 * 16), "R12");
        run(0, 0, 0, 32'h40, 16'd1, 32'h0, "R12");

        // R13 / R14 and mixed random chains
        for (int r = 0; r < 40; r++) begin
            hold_en = (r % 2) == 1;
            build_random(st);
            run(1, ($urandom % 2) == 1, ($urandom % 2) == 1, 32'h0, 16'(($urandom % 3)), st,
                hold_en ? "R13" : "R14");
        end
        hold_en = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule